// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block lets software on the host side reach the registers of external Ethernet PHY devices over the two-wire management bus. A single controller drives one MDC/MDIO pair, and both MAC ports of the chip share that bus. The controller sits behind a small register window. Software first loads the target PHY address and register address. It then does one of two things. Writing the outgoing data word starts a write frame. Setting a read bit in the command register starts a read frame.

The controller builds the full management frame and shifts it out MSB first. The frame is a run of ones as preamble, the start pattern, the opcode, both address fields, a turnaround, and sixteen data bits. MDC comes from the system clock through a divider that software can program. The controller changes MDIO only while MDC is low and samples read data on MDC rising edges. It lets go of the line for the turnaround and data bits of a read. A status word shows a busy flag and a data-not-valid flag. A repeat bit keeps reading the same register back to back, so software can poll a PHY without starting every read itself.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the status word (offset 3) reads 0, the read-data word (offset 2) reads 0, the command word (offset 1) reads 16'h0100, and MDC and the MDIO output enable are low.
- R2: The address word (offset 0) holds the PHY address in bits [12:8] and the register address in bits [4:0]. It reads back with all other bits zero.
- R3: While idle, a write to offset 2 launches a write frame. The frame on MDIO is 32 ones, then 01, then opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10, and the written 16-bit word, all MSB first.
- R4: Busy (status bit 0) is set one clock after the launching write. It clears exactly 128*(div+1) clocks after that write, where div is command bits [15:8].
- R5: While idle, a command write with bit 0 or bit 1 set launches a read frame with opcode 10. MDIO is released from the turnaround on. Data-not-valid (status bit 1) stays set from launch until busy clears. At that same edge, offset 2 holds the 16 bits sampled on MDC rising edges, MSB first.
- R6: Command bit 1 makes read frames run back to back, and offset 2 is refreshed at the end of each frame. A command write with bit 1 clear, made while busy, lets the current frame finish and then stops.
- R7: While busy, writes to offsets 0 and 2 are ignored, and so is any command write except one that clears the repeat bit. No extra frame results.
- R8: MDC is low and MDIO undriven while idle. MDC has a half period of div+1 clocks. MDIO and its enable change only while MDC is low.
- R9: Command bits [15:8] set div (reset value 1). The command word reads back as {div, 6'b0, repeat, 1'b0}.
- R10: Offset 3 is read-only: writing it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | MDIO value driven by the controller |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line value as seen at the pin |

## Verification
Busy rises one clock after the launching write and falls 128*(div+1) clocks after it. The bench counts falling clock edges from the launching write and reads the status word both one clock before that deadline and exactly at it. The read data and data-not-valid change on the same edge that busy falls, so they are checked in that same window, and during repeated reads they are checked a few clocks after each frame boundary. The frame content is checked on the MDC edges themselves: a PHY model decodes each completed frame and compares it with the next entry that the driver queued. An unexpected frame, such as one launched by an ignored write, finds the queue empty and is reported.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PRE_LEN = 32,
  parameter int DIV_RST = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME    = PRE_LEN + 32;
  localparam int BIT_W    = $clog2(FRAME);
  localparam int TA_POS   = PRE_LEN + 14;
  localparam int DATA_POS = PRE_LEN + 16;

  logic [4:0]       phy_q, rga_q;
  logic [7:0]       div_q, cnt_q;
  logic             rep_q, busy_q, nv_q, rd_q, mdc_q;
  logic [FRAME-1:0] sh_q;
  logic [BIT_W-1:0] bit_q;
  logic [15:0]      cap_q, rdat_q;

  function automatic logic [FRAME-1:0] mk_frame(input logic rd, input logic [4:0] pa,
                                                input logic [4:0] ra, input logic [15:0] d);
    return {{PRE_LEN{1'b1}}, 2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  wire tick      = busy_q && (cnt_q == div_q);
  wire rise      = tick && !mdc_q;
  wire fall      = tick && mdc_q;
  wire idle_we   = reg_we && !busy_q;
  wire launch_wr = idle_we && (reg_addr == 2'd2);
  wire launch_rd = idle_we && (reg_addr == 2'd1) && (reg_wdata[0] || reg_wdata[1]);
  wire last_bit  = (bit_q == BIT_W'(FRAME - 1));

  assign mdc     = mdc_q;
  assign mdio_o  = sh_q[FRAME-1];
  assign mdio_oe = busy_q && (!rd_q || bit_q < BIT_W'(TA_POS));

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {3'b0, phy_q, 3'b0, rga_q};
      2'd1:    reg_rdata = {div_q, 6'b0, rep_q, 1'b0};
      2'd2:    reg_rdata = rdat_q;
      default: reg_rdata = {14'b0, nv_q, busy_q};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q  <= '0;
      rga_q  <= '0;
      div_q  <= 8'(DIV_RST);
      cnt_q  <= '0;
      rep_q  <= 1'b0;
      busy_q <= 1'b0;
      nv_q   <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      cap_q  <= '0;
      rdat_q <= '0;
    end else begin
      if (idle_we && reg_addr == 2'd0) begin
        phy_q <= reg_wdata[12:8];
        rga_q <= reg_wdata[4:0];
      end
      if (idle_we && reg_addr == 2'd1) begin
        div_q <= reg_wdata[15:8];
        rep_q <= reg_wdata[1];
      end
      if (reg_we && busy_q && reg_addr == 2'd1 && !reg_wdata[1])
        rep_q <= 1'b0;

      if (launch_wr || launch_rd) begin
        busy_q <= 1'b1;
        rd_q   <= launch_rd;
        nv_q   <= launch_rd;
        sh_q   <= mk_frame(launch_rd, phy_q, rga_q, launch_rd ? 16'hFFFF : reg_wdata);
        bit_q  <= '0;
        cnt_q  <= '0;
        mdc_q  <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= tick ? '0 : cnt_q + 8'd1;
        if (tick)
          mdc_q <= ~mdc_q;
        if (rise && rd_q && bit_q >= BIT_W'(DATA_POS))
          cap_q <= {cap_q[14:0], mdio_i};
        if (fall) begin
          if (last_bit) begin
            if (rd_q) begin
              rdat_q <= cap_q;
              nv_q   <= 1'b0;
            end
            if (rd_q && rep_q) begin
              sh_q  <= mk_frame(1'b1, phy_q, rga_q, 16'hFFFF);
              bit_q <= '0;
            end else begin
              busy_q <= 1'b0;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
            sh_q  <= {sh_q[FRAME-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       busy,
  input logic       nv,
  input logic       mdc,
  input logic       mdo,
  input logic       mdoe,
  input logic [9:0] addr_reg
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdoe));

  p_mdio_steady_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdo) && $stable(mdoe)));

  p_launch_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !busy && reg_addr == 2'd2) |=> busy);

  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 2'd0) |=> $stable(addr_reg));

  p_nv_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nv |-> busy);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .busy(busy_q), .nv(nv_q), .mdc(mdc), .mdo(mdio_o), .mdoe(mdio_oe),
  .addr_reg({phy_q, rga_q})
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_en = 1'b0, phy_bit = 1'b0;
  wire mdio_line = mdio_oe ? mdio_o : (phy_en ? phy_bit : 1'b1);

  int ntot = 0, nfail = 0;
  bit finished = 1'b0;
  logic [26:0] sbq[$];
  int exp_serial = 0;

  always #10 clk = ~clk;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntot++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_val(input logic [4:0] p, input logic [4:0] r, input int n);
    return {3'b101, p, r, 3'(n)};
  endfunction

  // PHY model and monitor
  int ones = 0, cnt = 0, phy_serial = 0;
  bit inf = 0, pend = 0, cur_rd = 0;
  logic [29:0] fr = '0;
  logic [4:0] cur_phy = '0, cur_rg = '0;

  task automatic frame_done();
    logic [26:0] e;
    if (sbq.size() == 0) begin
      chk("R7 unexpected frame", 1, 0);
    end else begin
      e = sbq.pop_front();
      chk(e[26] ? "R5 read frame" : "R3 write frame", {2'b0, fr},
          {2'b0, e[26] ? 2'b10 : 2'b01, e[25:21], e[20:16], 2'b10, e[15:0]});
    end
    if (cur_rd) phy_serial++;
  endtask

  always @(posedge mdc) begin
    if (inf) begin
      fr = {fr[28:0], mdio_line};
      cnt++;
      if (cnt == 12) begin
        cur_rd  = (fr[11:10] == 2'b10);
        cur_phy = fr[9:5];
        cur_rg  = fr[4:0];
      end
      if (cnt == 30) begin
        inf = 0; ones = 0; pend = 0;
        frame_done();
      end
    end else if (pend) begin
      pend = 0;
      if (mdio_line) begin inf = 1; cnt = 0; end
      else ones = 0;
    end else if (mdio_line) begin
      ones++;
    end else if (ones >= 32) begin
      pend = 1;
    end else begin
      ones = 0;
    end
  end

  always @(negedge mdc) begin
    if (inf && cur_rd && cnt >= 13 && cnt <= 29) begin
      phy_en  = 1'b1;
      phy_bit = (cnt == 13) ? 1'b0 : phy_val(cur_phy, cur_rg, phy_serial)[29-cnt];
    end else begin
      phy_en = 1'b0;
    end
  end

  // driver
  task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic push(input bit rd, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    sbq.push_back({rd, p, r, d});
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rd_reg(2'd3, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  initial begin
    logic [15:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R9 reset state
    rd_reg(2'd3, v); chk("R1 status", v, 16'h0000);
    rd_reg(2'd2, v); chk("R1 rdata", v, 16'h0000);
    rd_reg(2'd1, v); chk("R9 cmd reset", v, 16'h0100);
    chk("R1 mdc/oe idle", {mdc, mdio_oe}, 2'b00);

    // R2 address layout
    wr_reg(2'd0, 16'hF3EA);
    rd_reg(2'd0, v); chk("R2 address readback", v, 16'h130A);

    // R10 status read-only
    wr_reg(2'd3, 16'hFFFF);
    rd_reg(2'd3, v); chk("R10 status unchanged", v, 16'h0000);
    chk("R10 no launch", {mdc, mdio_oe}, 2'b00);

    // R3 write frame, R7 ignored writes while busy
    push(1'b0, 5'h13, 5'h0A, 16'hBEEF);
    wr_reg(2'd2, 16'hBEEF);
    repeat (10) @(negedge clk);
    wr_reg(2'd0, 16'h0101);
    wr_reg(2'd2, 16'h1234);
    wr_reg(2'd1, 16'h0301);
    rd_reg(2'd0, v); chk("R7 address held", v, 16'h130A);
    rd_reg(2'd1, v); chk("R7 cmd held", v, 16'h0100);
    rd_reg(2'd3, v); chk("R7 status busy only", v, 16'h0001);
    wait_idle();
    repeat (300) @(negedge clk);
    chk("R7 queue drained", sbq.size(), 0);
    rd_reg(2'd3, v); chk("R7 stays idle", v, 16'h0000);

    // R4 busy duration, div=1 -> 256 clocks
    push(1'b0, 5'h13, 5'h0A, 16'h5A5A);
    wr_reg(2'd2, 16'h5A5A);
    repeat (255) @(negedge clk);
    rd_reg(2'd3, v); chk("R4 busy before deadline", v, 16'h0001);
    @(negedge clk);
    rd_reg(2'd3, v); chk("R4 idle at deadline", v, 16'h0000);

    // R5 single read
    wr_reg(2'd0, 16'h011F);
    push(1'b1, 5'h01, 5'h1F, phy_val(5'h01, 5'h1F, exp_serial));
    wr_reg(2'd1, 16'h0101);
    rd_reg(2'd3, v); chk("R5 busy and not-valid", v, 16'h0003);
    repeat (255) @(negedge clk);
    rd_reg(2'd3, v); chk("R5 not-valid before end", v, 16'h0003);
    @(negedge clk);
    rd_reg(2'd3, v); chk("R5 valid at end", v, 16'h0000);
    rd_reg(2'd2, v); chk("R5 read data", v, phy_val(5'h01, 5'h1F, exp_serial));
    exp_serial++;

    // R6 repeated reads
    wr_reg(2'd0, 16'h0705);
    for (int i = 0; i < 4; i++) push(1'b1, 5'h07, 5'h05, phy_val(5'h07, 5'h05, exp_serial + i));
    wr_reg(2'd1, 16'h0102);
    repeat (261) @(negedge clk);
    rd_reg(2'd2, v); chk("R6 first refresh", v, phy_val(5'h07, 5'h05, exp_serial));
    rd_reg(2'd3, v); chk("R6 still busy, valid", v, 16'h0001);
    repeat (256) @(negedge clk);
    rd_reg(2'd2, v); chk("R6 second refresh", v, phy_val(5'h07, 5'h05, exp_serial + 1));
    repeat (266) @(negedge clk);
    wr_reg(2'd1, 16'h0100);
    rd_reg(2'd1, v); chk("R6 repeat cleared", v, 16'h0100);
    wait_idle();
    rd_reg(2'd2, v); chk("R6 last frame data", v, phy_val(5'h07, 5'h05, exp_serial + 3));
    exp_serial += 4;
    repeat (600) @(negedge clk);
    chk("R6 stopped after four frames", sbq.size(), 0);
    rd_reg(2'd3, v); chk("R6 idle after stop", v, 16'h0000);

    // R9 / R4 divider 0 -> 128 clocks
    wr_reg(2'd1, 16'h0000);
    rd_reg(2'd1, v); chk("R9 div readback", v, 16'h0000);
    push(1'b0, 5'h07, 5'h05, 16'h8001);
    wr_reg(2'd2, 16'h8001);
    repeat (127) @(negedge clk);
    rd_reg(2'd3, v); chk("R4 div0 busy", v, 16'h0001);
    @(negedge clk);
    rd_reg(2'd3, v); chk("R4 div0 idle", v, 16'h0000);

    // R8 half period with div=2: mdc high for exactly 3 clocks
    wr_reg(2'd1, 16'h0200);
    push(1'b0, 5'h07, 5'h05, 16'h0F0F);
    wr_reg(2'd2, 16'h0F0F);
    chk("R8 mdc low at start", mdc, 1'b0);
    repeat (2) @(negedge clk);
    chk("R8 mdc low before half", mdc, 1'b0);
    @(negedge clk);
    chk("R8 mdc rises after half", mdc, 1'b1);
    repeat (2) @(negedge clk);
    chk("R8 mdc high held", mdc, 1'b1);
    @(negedge clk);
    chk("R8 mdc falls", mdc, 1'b0);
    repeat (377) @(negedge clk);
    rd_reg(2'd3, v); chk("R4 div2 busy", v, 16'h0001);
    @(negedge clk);
    rd_reg(2'd3, v); chk("R4 div2 idle", v, 16'h0000);
    chk("R8 idle quiet", {mdc, mdio_oe}, 2'b00);
    repeat (20) @(negedge clk);
    chk("R3 all frames seen", sbq.size(), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      ntot++; nfail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end
endmodule